// File: doc/BRIEF.md
# Reset Release Delay Mirror

This block copies a reset level from an always-powered domain onto a reset line that feeds a downstream controller. The two edges of the reset are treated differently. When the source reset falls, the output falls on the next clock edge. When the source reset rises, the output rises only after a programmable number of millisecond ticks. A downstream controller therefore enters reset without delay and leaves it only after its supplies have had time to settle.

The block acts only when the source level and the mirrored level disagree. It is serviced only while a rail-enable qualifier is high. While the qualifier is low the mirrored output holds its level. A release wait that is in progress when the qualifier drops is abandoned. A millisecond tick is derived from the clock by a prescaler whose division ratio is a parameter. The delay value is sampled when a release wait begins. A pending flag is high for as long as such a wait is running.

Top module: `rst_release_mirror`

## Requirements
- R1: After a clock edge with `rst` high, `rst_mir_o` is 0 and `rel_pend_o` is 0.
- R2: While `rail_en_i` is 1 and `rst_src_i` equals `rst_mir_o` with no wait pending, the next edge leaves `rst_mir_o` unchanged and `rel_pend_o` at 0.
- R3: With `rail_en_i` at 1, `rst_src_i` at 1, `rst_mir_o` at 0 and `rel_dly_i` = D > 0, the next edge raises `rel_pend_o`. `rst_mir_o` rises, and `rel_pend_o` falls, on the edge D*CYC_PER_MS edges after that one.
- R4: With `rel_dly_i` = 0, a rising mismatch is copied to `rst_mir_o` at the next edge, and `rel_pend_o` stays 0.
- R5: With `rail_en_i` at 1 and `rst_src_i` at 0, `rst_mir_o` is 0 after the next edge.
- R6: If `rst_src_i` returns to 0 while a wait is pending, the wait is cancelled at the next edge: `rel_pend_o` goes to 0 and `rst_mir_o` stays 0.
- R7: The delay is captured when the wait begins, and changes to `rel_dly_i` during the wait do not move the release edge.
- R8: While `rail_en_i` is 0, `rst_mir_o` holds its level whatever `rst_src_i` does, and `rel_pend_o` is 0 after the next edge. A wait that was in progress is abandoned, and the next wait starts over with the full delay.
- R9: `rel_pend_o` is never 1 while `rst_mir_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_src_i | input | 1 | Source reset level, 1 = released; synchronous to clk |
| rail_en_i | input | 1 | Service qualifier: rails enabled |
| rel_dly_i | input | DLY_W | Release delay in millisecond ticks |
| rst_mir_o | output | 1 | Mirrored reset toward the downstream controller |
| rel_pend_o | output | 1 | A release wait is running |

## Verification
On every cycle the checker enforces the reset state, the one-edge copy of a falling source, cancellation, holding while disabled, agreement-idle behaviour and the exclusion between pending and a high output. It also uses its own cycle counter, loaded with the captured delay, to check that a release happens exactly at the end of the window and not before. The bench scenarios show what a per-cycle property cannot: a delay that is changed during the wait and still does not move the release, a restart at full length after the qualifier drops, a zero-delay release, and a reset issued in the middle of a wait.

// File: rtl/rst_release_mirror_pkg.sv
package rst_release_mirror_pkg;

    // Width of a counter that must reach n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Controller view of one edge decision.
    typedef struct packed {
        logic start;    // begin a release wait (captures delay)
        logic fire;     // drive the mirror high
        logic drop;     // drive the mirror low
        logic abort;    // abandon a wait
    } mir_ctl_t;

    typedef enum logic [1:0] {
        MIR_HOLD  = 2'd0,
        MIR_FALL  = 2'd1,
        MIR_RISE  = 2'd2,
        MIR_WAIT  = 2'd3
    } mir_case_e;

endpackage

// File: rtl/rst_release_tick.sv
module rst_release_tick
    import rst_release_mirror_pkg::*;
#(
    parameter int CYC_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = cnt_width(CYC_PER_MS);
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = run && (div_q == LAST);
endmodule

// File: rtl/rst_release_msdelay.sv
module rst_release_msdelay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             clear,
    input  logic [DLY_W-1:0] dly_in,
    input  logic             tick,
    output logic             done
);
    logic [DLY_W-1:0] goal_q;
    logic [DLY_W-1:0] ms_q;
    logic [DLY_W:0]   ms_next;

    assign ms_next = {1'b0, ms_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            goal_q <= '0;
            ms_q   <= '0;
        end else if (load) begin
            goal_q <= dly_in;
            ms_q   <= '0;
        end else if (tick) begin
            ms_q <= ms_next[DLY_W-1:0];
        end
    end

    assign done = tick && (ms_next == {1'b0, goal_q});
endmodule

// File: rtl/rst_release_mirror.sv
module rst_release_mirror
    import rst_release_mirror_pkg::*;
#(
    parameter int CYC_PER_MS = 50000,
    parameter int DLY_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_src_i,
    input  logic             rail_en_i,
    input  logic [DLY_W-1:0] rel_dly_i,
    output logic             rst_mir_o,
    output logic             rel_pend_o
);
    logic      mir_q;
    logic      pend_q;
    logic      tick;
    logic      done;
    mir_case_e kase;
    mir_ctl_t  ctl;

    // Classify the relation between source and mirror.
    always_comb begin
        if (!rail_en_i)             kase = MIR_HOLD;
        else if (!rst_src_i)        kase = MIR_FALL;
        else if (mir_q)             kase = MIR_HOLD;
        else if (pend_q)            kase = MIR_WAIT;
        else                        kase = MIR_RISE;
    end

    always_comb begin
        ctl = '0;
        unique case (kase)
            MIR_HOLD: ctl.abort = !rail_en_i;
            MIR_FALL: begin
                ctl.drop  = 1'b1;
                ctl.abort = 1'b1;
            end
            MIR_RISE: begin
                if (rel_dly_i == '0) ctl.fire  = 1'b1;
                else                 ctl.start = 1'b1;
            end
            MIR_WAIT: ctl.fire = done;
            default:  ctl = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mir_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (ctl.drop)      mir_q <= 1'b0;
            else if (ctl.fire) mir_q <= 1'b1;

            if (ctl.abort || ctl.fire) pend_q <= 1'b0;
            else if (ctl.start)        pend_q <= 1'b1;
        end
    end

    rst_release_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (pend_q),
        .tick (tick)
    );

    rst_release_msdelay #(.DLY_W(DLY_W)) u_ms (
        .clk    (clk),
        .rst    (rst),
        .load   (ctl.start),
        .clear  (ctl.abort),
        .dly_in (rel_dly_i),
        .tick   (tick),
        .done   (done)
    );

    assign rst_mir_o  = mir_q;
    assign rel_pend_o = pend_q;
endmodule

// File: rtl/rst_release_mirror_chk.sv
module rst_release_mirror_chk #(
    parameter int CYC_PER_MS = 50000,
    parameter int DLY_W      = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rst_src_i,
    input logic             rail_en_i,
    input logic [DLY_W-1:0] rel_dly_i,
    input logic             rst_mir_o,
    input logic             rel_pend_o
);
    int               win_cnt;
    logic [DLY_W-1:0] cap_q;
    int               win_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= 0;
            cap_q   <= '0;
        end else begin
            win_cnt <= rel_pend_o ? win_cnt + 1 : 0;
            if (!rel_pend_o && rail_en_i && rst_src_i && !rst_mir_o)
                cap_q <= rel_dly_i;
        end
    end

    assign win_last = int'(cap_q) * CYC_PER_MS - 1;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!rst_mir_o && !rel_pend_o));

    // R2
    agree_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (rail_en_i && (rst_src_i == rst_mir_o) && !rel_pend_o)
        |=> ($stable(rst_mir_o) && !rel_pend_o));

    // R3
    release_on_time_chk: assert property (@(posedge clk) disable iff (rst)
        (rail_en_i && rst_src_i && rel_pend_o && win_cnt == win_last)
        |=> rst_mir_o);

    // R3
    no_early_release_chk: assert property (@(posedge clk) disable iff (rst)
        (rail_en_i && rst_src_i && rel_pend_o && win_cnt < win_last)
        |=> (!rst_mir_o && rel_pend_o));

    // R5
    fall_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (rail_en_i && !rst_src_i) |=> !rst_mir_o);

    // R6
    cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (rail_en_i && !rst_src_i && rel_pend_o) |=> (!rel_pend_o && !rst_mir_o));

    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rail_en_i |=> ($stable(rst_mir_o) && !rel_pend_o));

    // R9
    pend_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rel_pend_o && rst_mir_o));
endmodule

bind rst_release_mirror rst_release_mirror_chk #(
    .CYC_PER_MS(CYC_PER_MS),
    .DLY_W     (DLY_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rst_src_i  (rst_src_i),
    .rail_en_i  (rail_en_i),
    .rel_dly_i  (rel_dly_i),
    .rst_mir_o  (rst_mir_o),
    .rel_pend_o (rel_pend_o)
);

// File: tb/rst_release_mirror_tb.sv
module rst_release_mirror_tb;
    localparam int P  = 4;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          src = 1'b0;
    logic          en  = 1'b0;
    logic [DW-1:0] dly = '0;
    logic          mir;
    logic          pend;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic  o;
        logic  p;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    rst_release_mirror #(.CYC_PER_MS(P), .DLY_W(DW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .rst_src_i  (src),
        .rail_en_i  (en),
        .rel_dly_i  (dly),
        .rst_mir_o  (mir),
        .rel_pend_o (pend)
    );

    // Monitor: compare outputs just after each edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (mir !== e.o || pend !== e.p) begin
                bad++;
                $display("FAIL %s: mir/pend actual=%b%b expected=%b%b at cycle %0d",
                         e.tag, mir, pend, e.o, e.p, cyc);
            end
        end
    end

    // Driver: set inputs at the falling edge, queue the expected result.
    task automatic step(input logic r, input logic e, input logic s,
                        input logic [DW-1:0] d, input logic eo,
                        input logic ep, input string tag);
        exp_t it;
        rst = r; en = e; src = s; dly = d;
        it.o = eo; it.p = ep; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, "R1");
        // R2: agreement low, nothing happens
        for (int i = 0; i < 3; i++) step(0, 1, 0, 2, 0, 0, "R2");
        // R3: delayed release, D=2 -> 8 edges
        step(0, 1, 1, 2, 0, 1, "R3");
        for (int i = 0; i < 2*P-1; i++) step(0, 1, 1, 2, 0, 1, "R3");
        step(0, 1, 1, 2, 1, 0, "R3");
        // R2: agreement high
        for (int i = 0; i < 3; i++) step(0, 1, 1, 2, 1, 0, "R2");
        // R5: immediate assertion
        step(0, 1, 0, 2, 0, 0, "R5");
        // R6: cancel mid-wait, no later release
        for (int i = 0; i < 3; i++) step(0, 1, 1, 2, 0, 1, "R6");
        step(0, 1, 0, 2, 0, 0, "R6");
        for (int i = 0; i < 10; i++) step(0, 1, 0, 2, 0, 0, "R6");
        // R7: delay changed during the wait is ignored (D=1 captured)
        step(0, 1, 1, 1, 0, 1, "R7");
        for (int i = 0; i < P-1; i++) step(0, 1, 1, 3, 0, 1, "R7");
        step(0, 1, 1, 3, 1, 0, "R7");
        step(0, 1, 0, 3, 0, 0, "R5");
        // R4: zero delay copies at once
        step(0, 1, 1, 0, 1, 0, "R4");
        // R8: disabled, source drop ignored
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, "R8");
        step(0, 1, 0, 0, 0, 0, "R5");
        // R8: disable during a wait abandons it; restart takes full delay
        step(0, 1, 1, 2, 0, 1, "R8");
        for (int i = 0; i < 2; i++) step(0, 1, 1, 2, 0, 1, "R8");
        step(0, 0, 1, 2, 0, 0, "R8");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 2, 0, 0, "R8");
        step(0, 1, 1, 2, 0, 1, "R8");
        for (int i = 0; i < 2*P-1; i++) step(0, 1, 1, 2, 0, 1, "R8");
        step(0, 1, 1, 2, 1, 0, "R3");
        // R1: reset in the middle of a wait
        step(0, 1, 0, 2, 0, 0, "R5");
        for (int i = 0; i < 2; i++) step(0, 1, 1, 2, 0, 1, "R3");
        step(1, 1, 1, 2, 0, 0, "R1");
        step(0, 1, 1, 2, 0, 1, "R3");
        step(0, 1, 0, 2, 0, 0, "R6");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule